// File: doc/BRIEF.md
# Translation Table Pointer Generator

After a translation miss, a software or hardware refill handler must find the entry in an in-memory translation table that may hold the missing mapping. This block forms that entry address. Two page sizes are supported, and each has its own table. A select input picks the page size whose pointer is driven out. The block holds two register banks. One serves accesses whose context is zero. The other serves every other context. Each bank has one table base register per page size and one shared configuration register.

The block takes the latched miss tag as an input. That value holds the missing virtual page and, in its low bits, the context. The context field picks the bank. The base register supplies the upper address bits. A right-shifted, masked slice of the tag supplies the index, and the shift amount comes from the configured page-size code. For the second page size, a split flag in the base register forces one extra address bit, which selects the upper half of the table. The block also returns a tag-target word built from the miss tag, for comparison against the tags stored in the table. Both outputs are registered.

Top module: `tsbp_gen`

## Requirements
- R1: While reset is high, and on the first clock edge that samples it, `ptr_out` and `tgt_out` become zero. All base and configuration registers clear to zero.
- R2: When `wr_en` is high at a clock edge, `wr_data` is written into the register that `wr_sel` selects. The encoding is 0 = zero-context base for page size 0, 1 = zero-context base for page size 1, 2 = zero-context configuration, 3 = nonzero-context base for page size 0, 4 = nonzero-context base for page size 1, 5 = nonzero-context configuration. Codes 6 and 7 change no register. A configuration register keeps only `wr_data[2:0]`.
- R3: When `tag_acc[12:0]` is zero, the zero-context bank is used. Any other value selects the nonzero-context bank.
- R4: Pointer bits 63:13 hold the selected base register bits 63:13, OR-ed with the index bits and the split bit.
- R5: The index source is `tag_acc` shifted right by 9 + 3 × cfg[2:0] of the selected bank.
- R6: Only index bits 12+n down to 4 reach the pointer, where n = base[3:0]. Pointer bits 3:0 are always zero.
- R7: A base[3:0] value above 12 is treated as 12. The index therefore never reaches past bit 24.
- R8: When `ps_sel` = 1 and bit 12 of the selected base is set, pointer bit 13+n is forced to one. With `ps_sel` = 0, no bit is forced.
- R9: `ps_sel` = 0 uses the page-size-0 base and `ps_sel` = 1 uses the page-size-1 base. Both page sizes share the bank's configuration register.
- R10: `tgt_out` equals `tag_acc[63:22]` in bits 41:0, OR-ed with `tag_acc[12:0]` shifted left by 48. All other bits are zero.
- R11: Both outputs are registered. They reflect the inputs and register contents present at the previous clock edge, and they do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 64 | Register write data |
| tag_acc | input | 64 | Latched miss tag (virtual page and context) |
| ps_sel | input | 1 | Page-size pointer select |
| ptr_out | output | 64 | Table entry pointer |
| tgt_out | output | 64 | Tag-target readback word |

## Verification
`ptr_out` and `tgt_out` are due on the first rising edge after `tag_acc` or `ps_sel` is applied. A register write is visible in the pointer one edge after the edge that stores it. To respect those timings, the bench drives inputs on the falling edge, waits for the stated number of rising edges, and samples 1 ns later. A dedicated scenario samples just before the due edge and checks that the previous result still holds.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int DATA_W     = 64;
  localparam int CTX_W      = 13;
  localparam int CFG_W      = 3;
  localparam int SZ_W       = 4;
  localparam int IDX_LSB    = 4;
  localparam int SZ_LIM     = 12;
  localparam int PAGE_LSB   = 13;
  localparam int SPLIT_BIT  = 12;
  localparam int SHIFT_BASE = 9;
  localparam int SHIFT_STEP = 3;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_Z_PS0 = 3'd0,
    REG_Z_PS1 = 3'd1,
    REG_Z_CFG = 3'd2,
    REG_N_PS0 = 3'd3,
    REG_N_PS1 = 3'd4,
    REG_N_CFG = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/tsbp_regbank.sv
module tsbp_regbank
  import tsbp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CW  = CFG_W,
  parameter int SW  = SEL_W,
  parameter int NPS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SW-1:0]           wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ctx_zero,
  output logic [NPS-1:0][DW-1:0]  sel_base,
  output logic [CW-1:0]           sel_cfg
);
  logic [NPS-1:0][DW-1:0] base_z, base_n;
  logic [CW-1:0]          cfg_z, cfg_n;

  // One base register per page size in each bank.
  // Bank layout: codes 0..NPS-1 zero-context bases, NPS zero cfg,
  // NPS+1.. nonzero bases, 2*NPS+1 nonzero cfg.
  for (genvar j = 0; j < NPS; j++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst) begin
        base_z[j] <= '0;
        base_n[j] <= '0;
      end else if (wr_en) begin
        if (wr_sel == SW'(j))
          base_z[j] <= wr_data;
        if (wr_sel == SW'(NPS + 1 + j))
          base_n[j] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_z <= '0;
      cfg_n <= '0;
    end else if (wr_en) begin
      if (wr_sel == SW'(NPS))
        cfg_z <= wr_data[CW-1:0];
      if (wr_sel == SW'(2 * NPS + 1))
        cfg_n <= wr_data[CW-1:0];
    end
  end

  always_comb begin
    sel_base = ctx_zero ? base_z : base_n;
    sel_cfg  = ctx_zero ? cfg_z  : cfg_n;
  end
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc
  import tsbp_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int CW       = CFG_W,
  parameter int ZW       = SZ_W,
  parameter bit SPLIT_EN = 1'b0
) (
  input  logic [DW-1:0] base_i,
  input  logic [CW-1:0] cfg_i,
  input  logic [DW-1:0] tag_i,
  output logic [DW-1:0] ptr_o
);
  localparam int SHW = $clog2(SHIFT_BASE + SHIFT_STEP * ((1 << CW) - 1) + 1);
  localparam logic [DW-1:0] HI_MASK = {{(DW-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

  logic [ZW-1:0]  n_eff;
  logic [SHW-1:0] shamt;
  logic [DW-1:0]  shifted, mask, split_v;

  always_comb begin
    n_eff   = (base_i[ZW-1:0] > ZW'(SZ_LIM)) ? ZW'(SZ_LIM) : base_i[ZW-1:0];
    shamt   = SHW'(SHIFT_BASE) + SHW'(cfg_i) * SHW'(SHIFT_STEP);
    shifted = tag_i >> shamt;
    for (int b = 0; b < DW; b++)
      mask[b] = (b >= IDX_LSB) && (b <= SZ_LIM + int'(n_eff));
  end

  if (SPLIT_EN) begin : g_split
    always_comb
      split_v = base_i[SPLIT_BIT] ? (DW'(1) << (PAGE_LSB + int'(n_eff))) : '0;
  end else begin : g_nosplit
    always_comb split_v = '0;
  end

  always_comb ptr_o = (base_i & HI_MASK) | (shifted & mask) | split_v;
endmodule

// File: rtl/tsbp_gen.sv
module tsbp_gen
  import tsbp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CXW = CTX_W,
  parameter int CW  = CFG_W,
  parameter int SW  = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] tag_acc,
  input  logic          ps_sel,
  output logic [DW-1:0] ptr_out,
  output logic [DW-1:0] tgt_out
);
  localparam int NPS     = 2;
  localparam int TGT_SRC = 22;
  localparam int TGT_CTX = 48;

  logic                   ctx_zero;
  logic [NPS-1:0][DW-1:0] sel_base;
  logic [CW-1:0]          sel_cfg;
  logic [NPS-1:0][DW-1:0] ptr_ps;
  logic [DW-1:0]          cur_base;
  logic [DW-1:0]          tgt_next;

  always_comb ctx_zero = (tag_acc[CXW-1:0] == '0);

  tsbp_regbank #(.DW(DW), .CW(CW), .SW(SW), .NPS(NPS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctx_zero (ctx_zero),
    .sel_base (sel_base),
    .sel_cfg  (sel_cfg)
  );

  for (genvar j = 0; j < NPS; j++) begin : g_ps
    tsbp_ptr_calc #(.DW(DW), .CW(CW), .ZW(SZ_W), .SPLIT_EN(j == 1)) u_calc (
      .base_i (sel_base[j]),
      .cfg_i  (sel_cfg),
      .tag_i  (tag_acc),
      .ptr_o  (ptr_ps[j])
    );
  end

  always_comb begin
    cur_base = sel_base[ps_sel];
    tgt_next = (DW'(tag_acc) >> TGT_SRC) | (DW'(tag_acc[CXW-1:0]) << TGT_CTX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_out <= '0;
      tgt_out <= '0;
    end else begin
      ptr_out <= ptr_ps[ps_sel];
      tgt_out <= tgt_next;
    end
  end
endmodule

// File: rtl/tsbp_gen_chk.sv
module tsbp_gen_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] tag_acc,
  input logic [DW-1:0] cur_base,
  input logic [DW-1:0] ptr_out,
  input logic [DW-1:0] tgt_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (ptr_out == '0 && tgt_out == '0));

  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst) ptr_out[3:0] == 4'h0);

  // R4
  upper_base_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ptr_out[DW-1:26] == $past(cur_base[DW-1:26]));

  // R10
  tgt_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tgt_out[60:48] == $past(tag_acc[12:0]));

  // R10
  tgt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_out[47:42] == 6'h0 && tgt_out[63:61] == 3'h0);

  // R7
  idx_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ptr_out[DW-1:26] | $past(cur_base[DW-1:26])) == $past(cur_base[DW-1:26]));
endmodule

bind tsbp_gen tsbp_gen_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tag_acc  (tag_acc),
  .cur_base (cur_base),
  .ptr_out  (ptr_out),
  .tgt_out  (tgt_out)
);

// File: tb/tsbp_gen_test.sv
`timescale 1ns/1ps
module tsbp_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] tag_acc = '0;
  logic        ps_sel = 1'b0;
  logic [63:0] ptr_out, tgt_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] sh_reg [0:5];

  always #2.5 clk = ~clk;

  tsbp_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tag_acc(tag_acc), .ps_sel(ps_sel), .ptr_out(ptr_out), .tgt_out(tgt_out)
  );

  function automatic logic [63:0] exp_ptr(input logic [63:0] tag, input logic ps);
    logic [63:0] base, cfg, sh, r;
    int n, s, zi;
    zi   = (tag[12:0] == 13'd0) ? 0 : 3;
    base = sh_reg[zi + (ps ? 1 : 0)];
    cfg  = sh_reg[zi + 2];
    n = int'(base[3:0]);
    if (n > 12) n = 12;
    s  = 9 + 3 * int'(cfg[2:0]);
    sh = tag >> s;
    r  = {base[63:13], 13'd0};
    for (int b = 4; b <= 12 + n; b++) r[b] = r[b] | sh[b];
    if (ps && base[12]) r[13 + n] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] exp_tgt(input logic [63:0] tag);
    logic [63:0] r = '0;
    r[41:0]  = tag[63:22];
    r[60:48] = tag[12:0];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 3'd2 || sel == 3'd5) sh_reg[sel] = {61'd0, d[2:0]};
    else if (sel < 3'd6) sh_reg[sel] = d;
  endtask

  task automatic probe(input string req, input logic [63:0] tag, input logic ps);
    @(negedge clk);
    tag_acc = tag; ps_sel = ps;
    @(posedge clk); #1;
    check(req, ptr_out, exp_ptr(tag, ps));
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R1 ptr", ptr_out, 64'd0);
    check("R1 tgt", tgt_out, 64'd0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 6; i++) sh_reg[i] = '0;
    probe("R1 regs zero", 64'h0, 1'b0);
  endtask

  task automatic t_bank;
    wr(3'd0, 64'hA000_0000_0000_2003);
    wr(3'd1, 64'hB000_0000_0000_4005);
    wr(3'd2, 64'h1);
    wr(3'd3, 64'hC000_0000_0001_6006);
    wr(3'd4, 64'hD000_0000_0002_8002);
    wr(3'd5, 64'h2);
    probe("R3 ctx zero ps0", 64'h1234_5678_9ABC_E000, 1'b0);
    probe("R3 ctx nonzero ps0", 64'h1234_5678_9ABC_E001, 1'b0);
    probe("R9 ctx zero ps1", 64'h0FED_CBA9_8765_4000, 1'b1);
    probe("R9 ctx nonzero ps1", 64'h0FED_CBA9_8765_5FFF, 1'b1);
    probe("R4 base upper bits", 64'hFFFF_FFFF_FFFF_E000, 1'b0);
  endtask

  task automatic t_shift;
    wr(3'd0, 64'h5500_0000_0000_000C);
    for (int c = 0; c < 8; c++) begin
      wr(3'd2, 64'(c) | 64'hF0);
      probe("R5 shift by cfg", 64'hDEAD_BEEF_CAFE_0000 ^ (64'(c) << 40), 1'b0);
    end
  endtask

  task automatic t_mask;
    int szs[5] = '{0, 5, 12, 13, 15};
    wr(3'd2, 64'h0);
    foreach (szs[i]) begin
      wr(3'd0, 64'h7700_0000_0000_0000 | 64'(szs[i]));
      probe(szs[i] > 12 ? "R7 size clamp" : "R6 index mask", 64'hFFFF_FFFF_FFFF_E000, 1'b0);
      check("R6 low nibble", {60'd0, ptr_out[3:0]}, 64'd0);
    end
  endtask

  task automatic t_split;
    wr(3'd4, 64'h8800_0000_0000_1003);
    wr(3'd3, 64'h8800_0000_0000_1003);
    wr(3'd5, 64'h0);
    probe("R8 split ps1", 64'h0000_0000_0000_0007, 1'b1);
    check("R8 bit16 set", {63'd0, ptr_out[16]}, 64'd1);
    probe("R8 no split ps0", 64'h0000_0000_0000_0007, 1'b0);
    wr(3'd4, 64'h8800_0000_0000_100F);
    probe("R8 split clamped", 64'h0000_0000_0000_0009, 1'b1);
  endtask

  task automatic t_tgt;
    logic [63:0] tags[4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0040_1FFF, 64'h1357_9BDF_2468_A001};
    foreach (tags[i]) begin
      @(negedge clk); tag_acc = tags[i];
      @(posedge clk); #1;
      check("R10 tag target", tgt_out, exp_tgt(tags[i]));
    end
  endtask

  task automatic t_ignore;
    logic [63:0] t0 = 64'h2222_3333_4444_6000;
    logic [63:0] t1 = 64'h2222_3333_4444_6011;
    wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    probe("R2 code 6/7 ignored z0", t0, 1'b0);
    probe("R2 code 6/7 ignored z1", t0, 1'b1);
    probe("R2 code 6/7 ignored n0", t1, 1'b0);
    probe("R2 code 6/7 ignored n1", t1, 1'b1);
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFF9);
    probe("R2 cfg keeps 3 bits", t1, 1'b0);
  endtask

  task automatic t_latency;
    logic [63:0] old_p, old_t;
    logic [63:0] tb = 64'hABCD_0123_4567_8001;
    probe("R11 settle", 64'h1111_2222_3333_4000, 1'b0);
    old_p = ptr_out; old_t = tgt_out;
    @(negedge clk); tag_acc = tb; ps_sel = 1'b1;
    #2;
    check("R11 ptr holds before edge", ptr_out, old_p);
    check("R11 tgt holds before edge", tgt_out, old_t);
    @(posedge clk); #1;
    check("R11 ptr after edge", ptr_out, exp_ptr(tb, 1'b1));
    check("R11 tgt after edge", tgt_out, exp_tgt(tb));
  endtask

  initial begin
    t_reset();
    t_bank();
    t_shift();
    t_mask();
    t_split();
    t_tgt();
    t_ignore();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule